// File: doc/BRIEF.md
# Sector Transfer Termination Unit

This unit supervises one disk data transfer that spans one or more sectors and decides the cycle in which it ends and the status it reports. A transfer is launched with a first sector number, a final (end-of-track) sector number and a sector size code. Each host byte strobe advances a byte counter within the current sector. At each sector boundary the sector number either steps to the next sector or the transfer ends.

A transfer can end in four ways. An explicit terminal-count input ends it with normal status. Overrun and underrun flags end it with abnormal status. Reaching the end of the sector whose number equals the final sector number also ends it with abnormal status. Whatever the cause, the sector in progress is always completed. When the host stops part way through a sector, the unit generates the missing bytes itself as zeros, one per clock, until the sector boundary. The forwarded byte stream, a pad marker and a one-clock completion pulse with a 2-bit status are the outputs.

Top module: `sts_term_unit`

## Requirements
- R1: After reset, `busy`, `out_vld`, `done` and `cur_sec` are all zero.
- R2: A `start` pulse while idle loads `first_sec`, `eot_sec` and `size_code`, and `cur_sec` shows `first_sec`. A `start` pulse while busy is ignored, and `first_sec` is not sampled at any other time.
- R3: A sector holds 128 << `size_code` bytes, so codes 0, 1, 2 and 3 give 128, 256, 512 and 1024 bytes.
- R4: Each host byte accepted while transferring is output on `out_byte` with `out_vld`=1 and `out_pad`=0 one clock after its strobe.
- R5: After each completed sector, `cur_sec` increases by one. With no other cause, the transfer ends at the last byte of the sector numbered `eot_sec`, with `done_stat` = 01 (end of track).
- R6: A terminal count arriving before the last byte of a sector stops accepting host bytes. The rest of the sector is output as zero bytes with `out_pad`=1, one per clock, and the transfer ends at the sector's final byte with `done_stat` = 00.
- R7: A terminal count given together with the final byte of a sector ends the transfer at that byte with no padding and `done_stat` = 00. This holds even on the end-of-track sector.
- R8: Overrun ends the transfer like a terminal count but reports `done_stat` = 10. Underrun does the same and reports 11.
- R9: Only the first termination cause counts, and causes arriving during padding are ignored. When causes arrive in the same clock, overrun beats underrun, and underrun beats terminal count.
- R10: `done` is high for exactly one clock. That clock is the one in which the final byte is output, and `busy` is already low in it.
- R11: Terminal count, overrun and underrun have no effect while idle.
- R12: A cause that arrives before any byte of the current sector has been taken pads the whole sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a transfer (accepted only when idle) |
| first_sec | input | 8 | Number of the first sector |
| eot_sec | input | 8 | Number of the final sector of the track |
| size_code | input | 2 | Sector length code, 128 << code bytes |
| host_stb | input | 1 | Host byte strobe |
| host_byte | input | 8 | Host byte value |
| tc | input | 1 | Explicit terminal count |
| overrun | input | 1 | Overrun indication |
| underrun | input | 1 | Underrun indication |
| busy | output | 1 | Transfer in progress |
| cur_sec | output | 8 | Current sector number |
| out_vld | output | 1 | Output byte valid |
| out_pad | output | 1 | Output byte is a generated pad byte |
| out_byte | output | 8 | Output byte |
| done | output | 1 | One-clock completion pulse |
| done_stat | output | 2 | Completion status: 00 normal, 01 end of track, 10 overrun, 11 underrun |

## Verification
The bench places terminal count at the first byte, in mid-sector, on the final byte of an ordinary sector and on the final byte of the end-of-track sector. A design that pads one byte too many or too few shows the wrong total, and a design that lets the end-of-track check beat a terminal count reports 01 instead of 00. It also injects simultaneous and staggered causes, strobes the host during padding with nonzero data, and pulses start mid-transfer. These stimuli expose priority mistakes, host bytes leaking into the pad stream, and reloads of the sector number. Each of the four size codes is used, so an off-by-one in the sector length shows up as a wrong byte total.

// File: rtl/sts_pkg.sv
package sts_pkg;

    localparam int DATA_W   = 8;
    localparam int SEC_W    = 8;
    localparam int CODE_W   = 2;
    localparam int BASE_LEN = 128;
    localparam int MAX_CODE = (1 << CODE_W) - 1;
    localparam int CNT_W    = $clog2(BASE_LEN << MAX_CODE);

    typedef enum logic [1:0] {
        TS_NORMAL   = 2'd0,
        TS_EOT      = 2'd1,
        TS_OVERRUN  = 2'd2,
        TS_UNDERRUN = 2'd3
    } term_stat_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_XFER = 2'd1,
        PH_PAD  = 2'd2
    } phase_e;

    typedef struct packed {
        logic              vld;
        logic              pad;
        logic [DATA_W-1:0] data;
    } out_beat_t;

    typedef struct packed {
        logic       hit;
        term_stat_e code;
    } cause_t;

    // Priority among simultaneous causes: overrun, then underrun, then count.
    function automatic cause_t pick_cause(input logic tc_i, input logic ovr_i, input logic und_i);
        cause_t c;
        c.hit = tc_i | ovr_i | und_i;
        if (ovr_i)
            c.code = TS_OVERRUN;
        else if (und_i)
            c.code = TS_UNDERRUN;
        else
            c.code = TS_NORMAL;
        return c;
    endfunction

endpackage

// File: rtl/sts_byte_ctr.sv
module sts_byte_ctr #(
    parameter int CNT_W    = sts_pkg::CNT_W,
    parameter int CODE_W   = sts_pkg::CODE_W,
    parameter int BASE_LEN = sts_pkg::BASE_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    input  logic [CODE_W-1:0] size_code,
    output logic              last,
    output logic [CNT_W-1:0]  cnt
);
    localparam int NCODES = 1 << CODE_W;

    logic [CNT_W-1:0] lim [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_lim
        assign lim[g] = CNT_W'((BASE_LEN << g) - 1);
    end

    assign last = (cnt == lim[size_code]);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv)
            cnt <= last ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/sts_sec_trk.sv
module sts_sec_trk #(
    parameter int SEC_W = sts_pkg::SEC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [SEC_W-1:0] first_in,
    input  logic [SEC_W-1:0] final_in,
    output logic [SEC_W-1:0] cur,
    output logic             at_end
);
    logic [SEC_W-1:0] final_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            final_q <= '0;
        end else if (load) begin
            cur     <= first_in;
            final_q <= final_in;
        end else if (step) begin
            cur <= cur + 1'b1;
        end
    end

    assign at_end = (cur == final_q);
endmodule

// File: rtl/sts_cause.sv
module sts_cause (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            arm,
    input  logic            tc,
    input  logic            ovr,
    input  logic            und,
    output sts_pkg::cause_t eff
);
    import sts_pkg::*;

    cause_t held_q;
    cause_t fresh;

    assign fresh = pick_cause(arm & tc, arm & ovr, arm & und);
    assign eff   = held_q.hit ? held_q : fresh;

    always_ff @(posedge clk) begin
        if (rst || clr)
            held_q <= '{hit: 1'b0, code: TS_NORMAL};
        else if (!held_q.hit && fresh.hit)
            held_q <= fresh;
    end
endmodule

// File: rtl/sts_term_unit.sv
module sts_term_unit #(
    parameter int DATA_W   = sts_pkg::DATA_W,
    parameter int SEC_W    = sts_pkg::SEC_W,
    parameter int CODE_W   = sts_pkg::CODE_W,
    parameter int BASE_LEN = sts_pkg::BASE_LEN,
    localparam int CNT_W   = $clog2(BASE_LEN << ((1 << CODE_W) - 1))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SEC_W-1:0]  first_sec,
    input  logic [SEC_W-1:0]  eot_sec,
    input  logic [CODE_W-1:0] size_code,
    input  logic              host_stb,
    input  logic [DATA_W-1:0] host_byte,
    input  logic              tc,
    input  logic              overrun,
    input  logic              underrun,
    output logic              busy,
    output logic [SEC_W-1:0]  cur_sec,
    output logic              out_vld,
    output logic              out_pad,
    output logic [DATA_W-1:0] out_byte,
    output logic              done,
    output logic [1:0]        done_stat
);
    import sts_pkg::*;

    phase_e            phase_q, phase_d;
    logic [CODE_W-1:0] size_q;
    logic              done_q;
    term_stat_e        stat_q, stat_d;
    logic [DATA_W-1:0] beat_data_q;
    logic              beat_vld_q, beat_pad_q;

    logic       start_ok, in_xfer, in_pad, host_take, adv, sec_end;
    logic       last_byte, at_end, finish, step;
    cause_t     eff;
    logic [CNT_W-1:0] byte_cnt;

    assign start_ok  = start && (phase_q == PH_IDLE);
    assign in_xfer   = (phase_q == PH_XFER);
    assign in_pad    = (phase_q == PH_PAD);
    assign host_take = in_xfer && host_stb;
    assign adv       = host_take || in_pad;
    assign sec_end   = adv && last_byte;
    assign finish    = sec_end && (eff.hit || at_end);
    assign step      = sec_end && !finish;

    sts_byte_ctr #(
        .CNT_W   (CNT_W),
        .CODE_W  (CODE_W),
        .BASE_LEN(BASE_LEN)
    ) u_bytes (
        .clk      (clk),
        .rst      (rst),
        .clr      (start_ok),
        .adv      (adv),
        .size_code(size_q),
        .last     (last_byte),
        .cnt      (byte_cnt)
    );

    sts_sec_trk #(
        .SEC_W(SEC_W)
    ) u_sec (
        .clk     (clk),
        .rst     (rst),
        .load    (start_ok),
        .step    (step),
        .first_in(first_sec),
        .final_in(eot_sec),
        .cur     (cur_sec),
        .at_end  (at_end)
    );

    sts_cause u_cause (
        .clk(clk),
        .rst(rst),
        .clr(start_ok),
        .arm(in_xfer),
        .tc (tc),
        .ovr(overrun),
        .und(underrun),
        .eff(eff)
    );

    always_comb begin
        phase_d = phase_q;
        stat_d  = stat_q;
        unique case (phase_q)
            PH_IDLE: if (start_ok) phase_d = PH_XFER;
            PH_XFER: begin
                if (finish)
                    phase_d = PH_IDLE;
                else if (eff.hit)
                    phase_d = PH_PAD;
            end
            PH_PAD:  if (sec_end) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
        if (finish)
            stat_d = eff.hit ? eff.code : TS_EOT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            size_q      <= '0;
            done_q      <= 1'b0;
            stat_q      <= TS_NORMAL;
            beat_vld_q  <= 1'b0;
            beat_pad_q  <= 1'b0;
            beat_data_q <= '0;
        end else begin
            phase_q     <= phase_d;
            stat_q      <= stat_d;
            done_q      <= finish;
            beat_vld_q  <= adv;
            beat_pad_q  <= in_pad;
            beat_data_q <= host_take ? host_byte : '0;
            if (start_ok)
                size_q <= size_code;
        end
    end

    assign busy      = (phase_q != PH_IDLE);
    assign out_vld   = beat_vld_q;
    assign out_pad   = beat_pad_q;
    assign out_byte  = beat_data_q;
    assign done      = done_q;
    assign done_stat = stat_q;

    logic unused_cnt;
    assign unused_cnt = ^byte_cnt;
endmodule

// File: rtl/sts_term_unit_chk.sv
module sts_term_unit_chk #(
    parameter int DATA_W = sts_pkg::DATA_W,
    parameter int SEC_W  = sts_pkg::SEC_W
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic [SEC_W-1:0]  cur_sec,
    input logic              out_vld,
    input logic              out_pad,
    input logic [DATA_W-1:0] out_byte,
    input logic              done
);
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_at_final_byte: assert property (@(posedge clk) disable iff (rst)
        done |-> (out_vld && !busy));

    a_r6_pad_is_zero: assert property (@(posedge clk) disable iff (rst)
        out_pad |-> (out_vld && out_byte == '0));

    a_r4_output_follows_busy: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(busy));

    a_r11_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !out_vld);

    a_r5_sector_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && cur_sec != $past(cur_sec))
            |-> (cur_sec == SEC_W'($past(cur_sec) + 1'b1)));
endmodule

bind sts_term_unit sts_term_unit_chk #(
    .DATA_W(DATA_W),
    .SEC_W (SEC_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .cur_sec (cur_sec),
    .out_vld (out_vld),
    .out_pad (out_pad),
    .out_byte(out_byte),
    .done    (done)
);

// File: tb/sim_sts_term_unit.sv
module sim_sts_term_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] first_sec = '0;
    logic [7:0] eot_sec = '0;
    logic [1:0] size_code = '0;
    logic       host_stb = 1'b0;
    logic [7:0] host_byte = '0;
    logic       tc = 1'b0;
    logic       overrun = 1'b0;
    logic       underrun = 1'b0;
    logic       busy, out_vld, out_pad, done;
    logic [7:0] cur_sec, out_byte;
    logic [1:0] done_stat;

    always #2 clk = ~clk;

    sts_term_unit u0 (
        .clk(clk), .rst(rst), .start(start), .first_sec(first_sec),
        .eot_sec(eot_sec), .size_code(size_code), .host_stb(host_stb),
        .host_byte(host_byte), .tc(tc), .overrun(overrun), .underrun(underrun),
        .busy(busy), .cur_sec(cur_sec), .out_vld(out_vld), .out_pad(out_pad),
        .out_byte(out_byte), .done(done), .done_stat(done_stat)
    );

    int n_chk = 0;
    int n_bad = 0;
    int wd    = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'h80 | 8'(i & 8'h7f);
    endfunction

    // Monitor, sampled on the falling edge.
    logic mon_on = 1'b0;
    int m_total, m_pad, m_done, m_baddata, m_hidx, m_stat, m_sec, m_donebad;
    logic m_seen;

    always @(negedge clk) begin
        if (mon_on) begin
            if (out_vld) begin
                m_total++;
                if (out_pad) m_pad++;
                else begin
                    if (out_byte != pat(m_hidx)) m_baddata++;
                    m_hidx++;
                end
            end
            if (done) begin
                m_done++;
                m_stat = int'(done_stat);
                m_sec  = int'(cur_sec);
                if (busy || !out_vld) m_donebad++;
                m_seen = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", wd);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic run(input logic [7:0] ss, input logic [7:0] es, input logic [1:0] code,
                       input int tc_at, input int ovr_at, input int und_at,
                       input bit gap, input bit pre_tc, input int restart_at);
        m_total = 0; m_pad = 0; m_done = 0; m_baddata = 0; m_hidx = 0;
        m_stat = -1; m_sec = -1; m_donebad = 0; m_seen = 1'b0;
        mon_on = 1'b1;
        @(posedge clk); #1;
        first_sec = ss; eot_sec = es; size_code = code; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0; first_sec = 8'hEE;
        if (pre_tc) begin
            tc = 1'b1;
            @(posedge clk); #1;
            tc = 1'b0;
        end
        begin
            int i = 0;
            int cyc = 0;
            while (!m_seen && cyc < 6000) begin
                logic s;
                s = gap ? (cyc % 2 == 0) : 1'b1;
                host_stb  = s;
                host_byte = pat(i);
                tc        = s && (i == tc_at);
                overrun   = s && (i == ovr_at);
                underrun  = s && (i == und_at);
                start     = s && (i == restart_at);
                if (start) first_sec = 8'h77;
                @(posedge clk); #1;
                if (s) i++;
                cyc++;
                host_stb = 1'b0; tc = 1'b0; overrun = 1'b0; underrun = 1'b0; start = 1'b0;
            end
        end
        repeat (3) @(posedge clk);
        #1;
        mon_on = 1'b0;
        if (!m_seen) check("R10 done never seen", 0, 1);
    endtask

    typedef struct packed {
        logic [7:0]  ss;
        logic [7:0]  es;
        logic [1:0]  code;
        logic [1:0]  kind;
        logic [15:0] at;
        logic        gap;
        logic [15:0] total;
        logic [15:0] pad;
        logic [1:0]  stat;
        logic [7:0]  sec;
    } vec_t;

    // kind: 0 none, 1 terminal count, 2 overrun, 3 underrun
    localparam vec_t VECS [11] = '{
        '{8'd5, 8'd5, 2'd0, 2'd0, 16'd0,   1'b0, 16'd128,  16'd0,   2'd1, 8'd5}, // R3 R5
        '{8'd1, 8'd3, 2'd0, 2'd0, 16'd0,   1'b0, 16'd384,  16'd0,   2'd1, 8'd3}, // R5
        '{8'd2, 8'd2, 2'd1, 2'd0, 16'd0,   1'b0, 16'd256,  16'd0,   2'd1, 8'd2}, // R3
        '{8'd0, 8'd9, 2'd0, 2'd1, 16'd50,  1'b0, 16'd128,  16'd77,  2'd0, 8'd0}, // R6
        '{8'd0, 8'd9, 2'd0, 2'd1, 16'd127, 1'b0, 16'd128,  16'd0,   2'd0, 8'd0}, // R7
        '{8'd3, 8'd9, 2'd0, 2'd1, 16'd200, 1'b0, 16'd256,  16'd55,  2'd0, 8'd4}, // R6
        '{8'd1, 8'd4, 2'd0, 2'd2, 16'd10,  1'b0, 16'd128,  16'd117, 2'd2, 8'd1}, // R8
        '{8'd1, 8'd4, 2'd2, 2'd3, 16'd300, 1'b0, 16'd512,  16'd211, 2'd3, 8'd1}, // R8 R3
        '{8'd7, 8'd7, 2'd3, 2'd0, 16'd0,   1'b0, 16'd1024, 16'd0,   2'd1, 8'd7}, // R3
        '{8'd1, 8'd3, 2'd0, 2'd1, 16'd383, 1'b0, 16'd384,  16'd0,   2'd0, 8'd3}, // R7 R9
        '{8'd0, 8'd1, 2'd0, 2'd0, 16'd0,   1'b1, 16'd256,  16'd0,   2'd1, 8'd1}  // R4 gaps
    };

    task automatic check_run(input string tag, input int total, input int pad,
                             input int stat, input int sec);
        check({tag, " total bytes"}, m_total, total);
        check({tag, " pad bytes"}, m_pad, pad);
        check({tag, " status"}, m_stat, stat);
        check({tag, " final sector"}, m_sec, sec);
        check({tag, " R4 host data"}, m_baddata, 0);
        check({tag, " R10 done pulses"}, m_done, 1);
        check({tag, " R10 done timing"}, m_donebad, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 out_vld", int'(out_vld), 0);
        check("R1 done", int'(done), 0);
        check("R1 cur_sec", int'(cur_sec), 0);

        foreach (VECS[k]) begin
            vec_t v;
            v = VECS[k];
            run(v.ss, v.es, v.code,
                (v.kind == 2'd1) ? int'(v.at) : -1,
                (v.kind == 2'd2) ? int'(v.at) : -1,
                (v.kind == 2'd3) ? int'(v.at) : -1,
                v.gap, 1'b0, -1);
            check_run($sformatf("vec%0d", k), int'(v.total), int'(v.pad),
                      int'(v.stat), int'(v.sec));
        end

        // R2: start while busy is ignored
        run(8'd2, 8'd3, 2'd0, -1, -1, -1, 1'b0, 1'b0, 5);
        check_run("R2 restart ignored", 256, 0, 1, 3);

        // R11: causes while idle do nothing
        @(posedge clk); #1;
        tc = 1'b1; overrun = 1'b1; underrun = 1'b1;
        @(posedge clk); #1;
        tc = 1'b0; overrun = 1'b0; underrun = 1'b0;
        @(negedge clk);
        check("R11 idle busy", int'(busy), 0);
        check("R11 idle out_vld", int'(out_vld), 0);
        run(8'd4, 8'd4, 2'd0, -1, -1, -1, 1'b0, 1'b0, -1);
        check_run("R11 after idle causes", 128, 0, 1, 4);

        // R9: simultaneous overrun and count, overrun wins
        run(8'd0, 8'd5, 2'd0, 20, 20, -1, 1'b0, 1'b0, -1);
        check_run("R9 simultaneous", 128, 107, 2, 0);

        // R9: underrun during padding ignored
        run(8'd0, 8'd5, 2'd0, 10, -1, 30, 1'b0, 1'b0, -1);
        check_run("R9 late cause", 128, 117, 0, 0);

        // R12: count before any byte pads the whole sector
        run(8'd6, 8'd9, 2'd0, -1, -1, -1, 1'b0, 1'b1, -1);
        check_run("R12 empty sector", 128, 128, 0, 6);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule